// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block predicts the next fetch address before the fetched instruction has been decoded. It is a direct-mapped table. Each entry holds a valid flag, the address of a control-transfer instruction and the target that instruction last jumped to. The current fetch PC selects one entry by its index bits. The stored address is then compared with the full fetch PC. When they agree, the stored target is offered as the next PC. Otherwise the sequential address PC+4 is offered. Because the compare covers the whole address, an ordinary instruction that shares an index with a branch falls through to PC+4. It does not inherit a false target.

The execute stage reports every resolved instruction on a separate resolve port. The report carries the instruction's PC, whether it was a control transfer, whether it was taken, its actual target, and the next PC that fetch used for it. A taken control transfer claims its entry and evicts whatever was stored there. A not-taken branch that currently owns its entry releases it. Other instructions never write the table. One cycle after each report, the block flags a mispredict when the fetch guess differs from the real successor, and it presents the corrected address for the fetch redirect.

Top module: `btb_predictor`

## Requirements
- R1: When the entry selected by fetch_pc[8:2] is valid and its stored address bits [31:9] equal fetch_pc[31:9], pred_hit is 1 and pred_npc is the stored target, whose bits [1:0] read as zero. The lookup is combinational, in the same cycle. Address bits [1:0] take no part in the compare.
- R2: When the lookup does not hit, pred_hit is 0 and pred_npc equals fetch_pc + 4.
- R3: After reset no entry is valid, so every lookup misses, and kill is 0.
- R4: A resolve with res_is_ctrl=1 and res_taken=1 writes the entry at index res_pc[8:2]. The written entry is valid, holds the tag bits of res_pc, and holds res_target[31:2]. It replaces any previous occupant, including a different address with the same index.
- R5: A resolve with res_is_ctrl=1 and res_taken=0 whose PC currently hits in the table clears that entry's valid flag.
- R6: A resolve with res_is_ctrl=1 and res_taken=0 whose PC does not match the stored address at its index leaves that entry unchanged.
- R7: A resolve with res_is_ctrl=0 never changes the table, whatever the value of res_taken.
- R8: In the cycle after a resolve, kill is 1 exactly when the actual next PC differs from res_pred_npc. The actual next PC is res_target for a taken control transfer and res_pc + 4 in every other case. When kill is 1, redirect_pc holds that actual next PC.
- R9: kill is 0 in any cycle that does not follow a cycle with res_valid=1.
- R10: A table write first becomes visible to lookups in the cycle after the resolve. A lookup made in the same cycle as the write sees the old contents.
- R11: Two addresses that share index bits but differ in bits [31:9] contend for one entry. A fetch of the address that is not stored predicts PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_npc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved instruction is reported this cycle |
| res_pc | input | 32 | Address of the resolved instruction |
| res_is_ctrl | input | 1 | Resolved instruction is a branch or jump |
| res_taken | input | 1 | Control transfer was taken |
| res_target | input | 32 | Actual target of the control transfer |
| res_pred_npc | input | 32 | Next PC that fetch used after this instruction |
| kill | output | 1 | Prediction was wrong; younger work must be discarded |
| redirect_pc | output | 32 | Correct next PC when kill is set |

## Verification
The hardest situations to reach from the ports are the aliasing ones. One is an instruction that shares an index with a stored branch but has different upper bits, and then resolves not-taken or as a non-control instruction. It must leave the other address's entry alone. Another is a resolve writing the same entry that a lookup reads in the same cycle. Random addresses would almost never collide. The stimulus therefore draws PCs from four tag values crossed with eight index values, so collisions, evictions and invalidations happen often. Directed steps add a back-to-back fill/lookup, an alias fill that evicts, a not-taken alias and a non-control resolve with the taken bit set.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Write command produced by the resolve logic for the table
    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_FILL = 2'd1,
        WR_DROP = 2'd2
    } wr_op_e;

endpackage

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] pc_tag,
    input  logic                          ent_vld,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] ent_tag,
    output logic                          hit
);
    always_comb begin
        hit = ent_vld && (ent_tag == pc_tag);
    end
endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    // fetch read port
    input  logic [IDX_W-1:0]              a_idx,
    output logic                          a_vld,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] a_tag,
    output logic [ADDR_W-OFF_W-1:0]       a_tgt,
    // resolve read port (ownership check only)
    input  logic [IDX_W-1:0]              b_idx,
    output logic                          b_vld,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] b_tag,
    // write port
    input  wr_op_e                        wr_op,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [ADDR_W-IDX_W-OFF_W-1:0] wr_tag,
    input  logic [ADDR_W-OFF_W-1:0]       wr_tgt
);
    localparam int NUM   = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int TGT_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [TGT_W-1:0] tgt;
    } entry_t;

    entry_t ent_q [NUM];
    entry_t ent_d [NUM];

    for (genvar gi = 0; gi < NUM; gi++) begin : g_ent
        always_comb begin
            ent_d[gi] = ent_q[gi];
            if (wr_idx == IDX_W'(gi)) begin
                case (wr_op)
                    WR_FILL: begin
                        ent_d[gi].vld = 1'b1;
                        ent_d[gi].tag = wr_tag;
                        ent_d[gi].tgt = wr_tgt;
                    end
                    WR_DROP: ent_d[gi].vld = 1'b0;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[gi] <= '0;
            end else begin
                ent_q[gi] <= ent_d[gi];
            end
        end
    end

    always_comb begin
        a_vld = ent_q[a_idx].vld;
        a_tag = ent_q[a_idx].tag;
        a_tgt = ent_q[a_idx].tgt;
        b_vld = ent_q[b_idx].vld;
        b_tag = ent_q[b_idx].tag;
    end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          res_valid,
    input  logic [ADDR_W-1:0]             res_pc,
    input  logic                          res_is_ctrl,
    input  logic                          res_taken,
    input  logic [ADDR_W-1:0]             res_target,
    input  logic [ADDR_W-1:0]             res_pred_npc,
    input  logic                          res_owns,
    output wr_op_e                        wr_op,
    output logic [IDX_W-1:0]              wr_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0] wr_tag,
    output logic [ADDR_W-OFF_W-1:0]       wr_tgt,
    output logic                          kill,
    output logic [ADDR_W-1:0]             redirect_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << OFF_W);

    typedef struct packed {
        logic              kill;
        logic [ADDR_W-1:0] redir;
    } state_t;

    state_t st_q, st_d;
    logic [ADDR_W-1:0] actual_npc;
    logic              jump;

    always_comb begin
        jump       = res_is_ctrl && res_taken;
        actual_npc = jump ? res_target : (res_pc + STEP);

        wr_idx = res_pc[IDX_W+OFF_W-1:OFF_W];
        wr_tag = res_pc[ADDR_W-1:IDX_W+OFF_W];
        wr_tgt = res_target[ADDR_W-1:OFF_W];
        wr_op  = WR_NONE;
        if (res_valid && res_is_ctrl) begin
            if (res_taken)     wr_op = WR_FILL;
            else if (res_owns) wr_op = WR_DROP;
        end

        st_d       = st_q;
        st_d.kill  = res_valid && (actual_npc != res_pred_npc);
        if (res_valid) st_d.redir = actual_npc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kill        = st_q.kill;
    assign redirect_pc = st_q.redir;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_npc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_is_ctrl,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic [ADDR_W-1:0] res_pred_npc,
    output logic              kill,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int TGT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << OFF_W);

    logic             a_vld, b_vld, a_hit, b_hit;
    logic [TAG_W-1:0] a_tag, b_tag, wr_tag;
    logic [TGT_W-1:0] a_tgt, wr_tgt;
    logic [IDX_W-1:0] wr_idx;
    wr_op_e           wr_op;

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (fetch_pc[IDX_W+OFF_W-1:OFF_W]),
        .a_vld  (a_vld),
        .a_tag  (a_tag),
        .a_tgt  (a_tgt),
        .b_idx  (res_pc[IDX_W+OFF_W-1:OFF_W]),
        .b_vld  (b_vld),
        .b_tag  (b_tag),
        .wr_op  (wr_op),
        .wr_idx (wr_idx),
        .wr_tag (wr_tag),
        .wr_tgt (wr_tgt)
    );

    btb_tag_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_match_fetch (
        .pc_tag  (fetch_pc[ADDR_W-1:IDX_W+OFF_W]),
        .ent_vld (a_vld),
        .ent_tag (a_tag),
        .hit     (a_hit)
    );

    btb_tag_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_match_res (
        .pc_tag  (res_pc[ADDR_W-1:IDX_W+OFF_W]),
        .ent_vld (b_vld),
        .ent_tag (b_tag),
        .hit     (b_hit)
    );

    btb_resolve #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_pc       (res_pc),
        .res_is_ctrl  (res_is_ctrl),
        .res_taken    (res_taken),
        .res_target   (res_target),
        .res_pred_npc (res_pred_npc),
        .res_owns     (b_hit),
        .wr_op        (wr_op),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_tgt       (wr_tgt),
        .kill         (kill),
        .redirect_pc  (redirect_pc)
    );

    always_comb begin
        pred_hit = a_hit;
        pred_npc = a_hit ? {a_tgt, OFF_W'(0)} : (fetch_pc + STEP);
    end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_npc,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_is_ctrl,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic [ADDR_W-1:0] res_pred_npc,
    input logic              kill,
    input logic [ADDR_W-1:0] redirect_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << OFF_W);

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_npc == fetch_pc + STEP);  // R2

    AST_HIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> pred_npc[OFF_W-1:0] == '0);  // R1

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_ctrl && res_taken) |=>
        (fetch_pc[ADDR_W-1:OFF_W] != $past(res_pc[ADDR_W-1:OFF_W])) ||
        (pred_hit && pred_npc[ADDR_W-1:OFF_W] == $past(res_target[ADDR_W-1:OFF_W])));  // R4

    AST_NOT_TAKEN_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_is_ctrl && !res_taken) |=>
        (fetch_pc[ADDR_W-1:OFF_W] != $past(res_pc[ADDR_W-1:OFF_W])) || !pred_hit);  // R5

    AST_KILL_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> $past(res_valid));  // R9

    AST_REDIRECT_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> redirect_pc != $past(res_pred_npc));  // R8
endmodule

bind btb_predictor btb_predictor_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic [31:0] pred_npc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_is_ctrl = 1'b0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic [31:0] res_pred_npc = '0;
    logic        kill;
    logic [31:0] redirect_pc;

    int vectors = 0;
    int errors  = 0;

    // reference model
    logic        m_vld [128];
    logic [22:0] m_tag [128];
    logic [29:0] m_tgt [128];

    logic        exp_kill = 1'b0;
    logic [31:0] exp_redir = '0;

    always #4 clk = ~clk;

    btb_predictor dut (.*);

    function automatic logic m_hit(input logic [31:0] pc);
        return m_vld[pc[8:2]] && (m_tag[pc[8:2]] == pc[31:9]);
    endfunction

    function automatic logic [31:0] m_npc(input logic [31:0] pc);
        return m_hit(pc) ? {m_tgt[pc[8:2]], 2'b00} : pc + 32'd4;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, check lookup and last resolve, advance
    task automatic step(input string req, input logic [31:0] fpc, input logic rv,
                        input logic [31:0] rpc, input logic ctrl, input logic tk,
                        input logic [31:0] tgt, input logic [31:0] pnpc);
        logic [31:0] act_npc;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_is_ctrl = ctrl;
        res_taken = tk; res_target = tgt; res_pred_npc = pnpc;
        #1;
        check({req, " R1 R2 hit"}, 32'(pred_hit), 32'(m_hit(fpc)));
        check({req, " R1 R2 npc"}, pred_npc, m_npc(fpc));
        check({req, " R8 R9 kill"}, 32'(kill), 32'(exp_kill));
        if (exp_kill) check({req, " R8 redirect"}, redirect_pc, exp_redir);
        act_npc  = (ctrl && tk) ? tgt : rpc + 32'd4;
        exp_kill = rv && (act_npc != pnpc);
        exp_redir = act_npc;
        @(posedge clk);
        if (rv && ctrl) begin
            if (tk) begin
                m_vld[rpc[8:2]] = 1'b1;
                m_tag[rpc[8:2]] = rpc[31:9];
                m_tgt[rpc[8:2]] = tgt[31:2];
            end else if (m_hit(rpc)) begin
                m_vld[rpc[8:2]] = 1'b0;
            end
        end
    endtask

    function automatic logic [31:0] rnd_pc();
        logic [22:0] tags [4] = '{23'h000123, 23'h0004a5, 23'h7ff001, 23'h1abcde};
        return {tags[$urandom % 4], 7'($urandom % 8), 2'b00};
    endfunction

    initial begin
        #(8ns * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'd20251));
        for (int i = 0; i < 128; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: empty after reset
        for (int i = 0; i < 4; i++)
            step("R3 empty", 32'h0000_0100 + 32'(i * 4), 1'b0, '0, 1'b0, 1'b0, '0, '0);

        a = 32'h1000_0040;
        b = a + 32'h0000_0200;   // same index, different tag
        // R10: fill while fetching the same PC: old contents seen
        step("R10 same-cycle", a, 1'b1, a, 1'b1, 1'b1, 32'h2000_0000, a + 4);
        step("R4 R1 fill visible", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        step("R11 alias miss", b, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R7: non-control with taken set
        step("R7 nonctrl", b, 1'b1, b, 1'b0, 1'b1, 32'h3000_0000, b + 4);
        step("R7 after", b, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        step("R7 owner kept", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R6: not-taken alias leaves owner
        step("R6 nt alias", a, 1'b1, b, 1'b1, 1'b0, '0, b + 4);
        step("R6 owner kept", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R4: alias fill evicts owner
        step("R4 evict", b, 1'b1, b, 1'b1, 1'b1, 32'h0400_0010, b + 4);
        step("R4 evicted", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        step("R4 new owner", b, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R5: not-taken owner drops
        step("R5 drop", b, 1'b1, b, 1'b1, 1'b0, '0, 32'h0400_0010);
        step("R5 dropped", b, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        // R8 correct prediction, then R9 idle
        step("R8 correct", a, 1'b1, a, 1'b1, 1'b1, 32'h0000_8000, 32'h0000_8000);
        step("R9 idle", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);
        step("R9 idle2", a, 1'b0, '0, 1'b0, 1'b0, '0, '0);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f, r, t, p;
            logic rv, c, k;
            f  = rnd_pc();
            r  = rnd_pc();
            rv = ($urandom % 4) != 0;
            c  = ($urandom % 4) != 0;
            k  = ($urandom % 2) != 0;
            t  = {4'h4, 8'($urandom % 16), 18'($urandom), 2'b00};
            case ($urandom % 4)
                0:       p = r + 32'd4;
                1:       p = t;
                default: p = m_npc(r);
            endcase
            step("rand", f, rv, r, c, k, t, p);
        end
        step("final", 32'h0, 1'b0, '0, 1'b0, 1'b0, '0, '0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule